// File: doc/BRIEF.md
# Daisy-Chain Byte Relay with Frame Tracking

This block sits in a daisy-chain node between the bit demodulator and the serializer that drives the next link. Every byte the demodulator hands over is passed on one cycle later, whether or not it arrived intact. If the local receiver reported any fault for that byte, or the byte already carried its error tag, the outgoing copy has its error tag set. Devices further along the chain therefore learn that the byte must be ignored.

Alongside the relay path, the block follows frame boundaries for the local consumer. A byte with the start-of-frame bit opens a frame. Its length is taken from a length input at that moment. Clean bytes are delivered locally until the frame is complete. A start-of-frame byte that arrives while a frame is still open abandons that frame and restarts framing. The block also emits masked single-cycle fault pulses, and it can force the start-of-frame bit onto the next relayed byte after a host break request.

Top module: `dcr_byte_relay`

## Requirements
- R1: For every cycle with `rx_valid` high, `tx_valid` is high in the next cycle with `tx_data` equal to `rx_data`. `tx_valid` is low in the cycle after a cycle without `rx_valid`.
- R2: The relayed `tx_berr` is 1 when the incoming `rx_berr` is 1 or any bit of `rx_fault` is 1, and 0 otherwise.
- R3: A `break_req` pulse makes the next relayed byte carry `tx_sof` = 1. This holds when the pulse comes in the same cycle as that byte or in any earlier idle cycle. Only that one byte is affected. Without a break, `tx_sof` equals the byte's `rx_sof`.
- R4: A byte with `rx_berr` = 1 gives a `flt_berr` pulse one cycle later (when unmasked). That byte is never delivered locally and does not change the frame state.
- R5: A byte with any `rx_fault` bit set is not delivered locally, does not change the frame state and raises no `flt_berr` pulse.
- R6: A clean byte (no error tag, no local fault) with `rx_sof` = 1 is delivered with `loc_first` = 1. It opens a frame of `frm_len`+1 bytes, where `frm_len` is sampled from that byte's cycle.
- R7: A clean byte with `rx_sof` = 0 while no frame is open is relayed but not delivered locally.
- R8: The clean byte that completes the frame is delivered with `loc_last` = 1, and the frame closes. With `frm_len` = 0 the start byte is both first and last.
- R9: A clean start-of-frame byte that arrives while a frame is open produces a one-cycle `loc_discard` and a `flt_sof` pulse (when unmasked). The same byte opens the new frame as its first byte.
- R10: Local outputs and fault pulses appear one cycle after the byte's input cycle. `loc_discard` is never masked.
- R11: `berr_mask` = 1 suppresses `flt_berr`, and `sof_mask` = 1 suppresses `flt_sof`. Each mask is sampled in the byte's cycle and does not affect relaying or delivery.
- R12: While reset is high, and in the cycle after it is released, all valid, flag and fault outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A demodulated byte is present this cycle |
| rx_data | input | 8 | Received data byte |
| rx_sof | input | 1 | Received start-of-frame bit |
| rx_berr | input | 1 | Received byte-error tag |
| rx_fault | input | 5 | Local receiver fault flags for this byte |
| frm_len | input | 6 | Frame length minus one, sampled on a start byte |
| break_req | input | 1 | Host break: tag the next relayed byte as frame start |
| berr_mask | input | 1 | Suppresses the byte-error fault pulse |
| sof_mask | input | 1 | Suppresses the unexpected-start fault pulse |
| tx_valid | output | 1 | Relayed byte valid |
| tx_data | output | 8 | Relayed data byte |
| tx_sof | output | 1 | Relayed start-of-frame bit |
| tx_berr | output | 1 | Relayed byte-error tag |
| loc_valid | output | 1 | Byte delivered to the local consumer |
| loc_data | output | 8 | Locally delivered byte |
| loc_first | output | 1 | Delivered byte opens a frame |
| loc_last | output | 1 | Delivered byte completes a frame |
| loc_discard | output | 1 | Open frame abandoned |
| flt_berr | output | 1 | Incoming byte-error fault pulse |
| flt_sof | output | 1 | Unexpected start-of-frame fault pulse |

## Verification
Each output path has exactly one register, so the relayed byte, the local delivery, the discard pulse and both fault pulses are all due in the cycle after the byte is presented. The bench drives each byte on a falling edge. It samples every output on the following falling edge, which is after the single capturing rising edge and before the next byte is driven. A break request issued in an idle cycle is checked on the first byte that follows. Framing is followed across faulted and tagged bytes to show that these bytes leave the frame count unchanged.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned FAULT_N = 5;
    localparam int unsigned LEN_W   = 6;

    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_OPEN = 1'b1
    } fr_state_e;

    typedef struct packed {
        logic berr;
        logic sof;
    } flt_evt_t;

    function automatic logic byte_is_bad(input logic tag, input logic [FAULT_N-1:0] flags);
        return tag | (|flags);
    endfunction

endpackage

// File: rtl/dcr_tx_tag.sv
module dcr_tx_tag #(
    parameter int unsigned DW   = dcr_pkg::BYTE_W,
    parameter int unsigned NFLT = dcr_pkg::FAULT_N
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_valid,
    input  logic [DW-1:0]   rx_data,
    input  logic            rx_sof,
    input  logic            rx_berr,
    input  logic [NFLT-1:0] rx_fault,
    input  logic            break_req,
    output logic            tx_valid,
    output logic [DW-1:0]   tx_data,
    output logic            tx_sof,
    output logic            tx_berr
);
    logic brk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_q    <= 1'b0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
            tx_sof   <= 1'b0;
            tx_berr  <= 1'b0;
        end else begin
            tx_valid <= rx_valid;
            if (rx_valid) begin
                tx_data <= rx_data;
                tx_sof  <= rx_sof | brk_q | break_req;
                tx_berr <= rx_berr | (|rx_fault);
                brk_q   <= 1'b0;
            end else begin
                tx_sof  <= 1'b0;
                tx_berr <= 1'b0;
                if (break_req) begin
                    brk_q <= 1'b1;
                end
            end
        end
    end

    p_follow_r1: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> (tx_valid && tx_data == $past(rx_data)));
    p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !tx_valid);
    p_tag_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && (|rx_fault)) |=> tx_berr);
    p_brk_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && (brk_q || break_req)) |=> tx_sof);
endmodule

// File: rtl/dcr_frame_trk.sv
module dcr_frame_trk #(
    parameter int unsigned DW   = dcr_pkg::BYTE_W,
    parameter int unsigned LENW = dcr_pkg::LEN_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_valid,
    input  logic [DW-1:0]   acc_data,
    input  logic            acc_sof,
    input  logic [LENW-1:0] frm_len,
    output logic            clash,
    output logic            loc_valid,
    output logic [DW-1:0]   loc_data,
    output logic            loc_first,
    output logic            loc_last,
    output logic            loc_discard
);
    import dcr_pkg::*;

    localparam logic [LENW-1:0] ONE = LENW'(1);

    fr_state_e       st_q;
    logic [LENW-1:0] rem_q;

    assign clash = acc_valid && acc_sof && (st_q == FR_OPEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= FR_IDLE;
            rem_q       <= '0;
            loc_valid   <= 1'b0;
            loc_data    <= '0;
            loc_first   <= 1'b0;
            loc_last    <= 1'b0;
            loc_discard <= 1'b0;
        end else begin
            loc_valid   <= 1'b0;
            loc_first   <= 1'b0;
            loc_last    <= 1'b0;
            loc_discard <= 1'b0;
            if (acc_valid) begin
                if (acc_sof) begin
                    loc_valid   <= 1'b1;
                    loc_data    <= acc_data;
                    loc_first   <= 1'b1;
                    loc_discard <= clash;
                    rem_q       <= frm_len;
                    if (frm_len == '0) begin
                        loc_last <= 1'b1;
                        st_q     <= FR_IDLE;
                    end else begin
                        st_q     <= FR_OPEN;
                    end
                end else if (st_q == FR_OPEN) begin
                    loc_valid <= 1'b1;
                    loc_data  <= acc_data;
                    rem_q     <= rem_q - ONE;
                    if (rem_q == ONE) begin
                        loc_last <= 1'b1;
                        st_q     <= FR_IDLE;
                    end
                end
            end
        end
    end

    p_discard_first_r9: assert property (@(posedge clk) disable iff (rst)
        loc_discard |-> (loc_valid && loc_first));
    p_closed_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_sof && st_q == FR_IDLE) |=> !loc_valid);
    p_last_closes_r8: assert property (@(posedge clk) disable iff (rst)
        (loc_valid && loc_last) |-> (st_q == FR_IDLE));
    p_open_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == FR_OPEN) |-> (rem_q != '0));
endmodule

// File: rtl/dcr_flt_gate.sv
module dcr_flt_gate
    import dcr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  flt_evt_t evt,
    input  flt_evt_t mask,
    output flt_evt_t flt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flt <= '0;
        end else begin
            flt <= evt & ~mask;
        end
    end

    p_mask_berr_r11: assert property (@(posedge clk) disable iff (rst)
        mask.berr |=> !flt.berr);
    p_mask_sof_r11: assert property (@(posedge clk) disable iff (rst)
        mask.sof |=> !flt.sof);
    p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        evt.berr && !mask.berr |=> flt.berr);
endmodule

// File: rtl/dcr_byte_relay.sv
module dcr_byte_relay #(
    parameter int unsigned DW   = dcr_pkg::BYTE_W,
    parameter int unsigned NFLT = dcr_pkg::FAULT_N,
    parameter int unsigned LENW = dcr_pkg::LEN_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_valid,
    input  logic [DW-1:0]   rx_data,
    input  logic            rx_sof,
    input  logic            rx_berr,
    input  logic [NFLT-1:0] rx_fault,
    input  logic [LENW-1:0] frm_len,
    input  logic            break_req,
    input  logic            berr_mask,
    input  logic            sof_mask,
    output logic            tx_valid,
    output logic [DW-1:0]   tx_data,
    output logic            tx_sof,
    output logic            tx_berr,
    output logic            loc_valid,
    output logic [DW-1:0]   loc_data,
    output logic            loc_first,
    output logic            loc_last,
    output logic            loc_discard,
    output logic            flt_berr,
    output logic            flt_sof
);
    import dcr_pkg::*;

    logic     acc_valid;
    logic     clash;
    flt_evt_t evt;
    flt_evt_t msk;
    flt_evt_t flt;

    assign acc_valid = rx_valid && !byte_is_bad(rx_berr, rx_fault);

    dcr_tx_tag #(.DW(DW), .NFLT(NFLT)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_sof    (rx_sof),
        .rx_berr   (rx_berr),
        .rx_fault  (rx_fault),
        .break_req (break_req),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_sof    (tx_sof),
        .tx_berr   (tx_berr)
    );

    dcr_frame_trk #(.DW(DW), .LENW(LENW)) u_frm (
        .clk         (clk),
        .rst         (rst),
        .acc_valid   (acc_valid),
        .acc_data    (rx_data),
        .acc_sof     (rx_sof),
        .frm_len     (frm_len),
        .clash       (clash),
        .loc_valid   (loc_valid),
        .loc_data    (loc_data),
        .loc_first   (loc_first),
        .loc_last    (loc_last),
        .loc_discard (loc_discard)
    );

    always_comb begin
        evt.berr = rx_valid && rx_berr;
        evt.sof  = clash;
        msk.berr = berr_mask;
        msk.sof  = sof_mask;
    end

    dcr_flt_gate u_flt (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .mask (msk),
        .flt  (flt)
    );

    assign flt_berr = flt.berr;
    assign flt_sof  = flt.sof;

    p_bad_nodeliver_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_berr) |=> (!loc_valid && !loc_discard));
    p_fault_nodeliver_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && (|rx_fault)) |=> !loc_valid);
    p_fault_noberr_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_berr) |=> !flt_berr);
    p_sof_has_discard_r9: assert property (@(posedge clk) disable iff (rst)
        flt_sof |-> loc_discard);
    p_reset_quiet_r12: assert property (@(posedge clk)
        $past(rst) |-> (!tx_valid && !loc_valid && !flt_berr && !flt_sof));
endmodule

// File: tb/test_dcr_byte_relay.sv
module test_dcr_byte_relay;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_sof = 1'b0;
    logic       rx_berr = 1'b0;
    logic [4:0] rx_fault = '0;
    logic [5:0] frm_len = '0;
    logic       break_req = 1'b0;
    logic       berr_mask = 1'b0;
    logic       sof_mask = 1'b0;
    logic       tx_valid, tx_sof, tx_berr;
    logic [7:0] tx_data, loc_data;
    logic       loc_valid, loc_first, loc_last, loc_discard, flt_berr, flt_sof;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    dcr_byte_relay i_dcr_byte_relay (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_berr(rx_berr), .rx_fault(rx_fault),
        .frm_len(frm_len), .break_req(break_req), .berr_mask(berr_mask),
        .sof_mask(sof_mask), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_sof(tx_sof), .tx_berr(tx_berr), .loc_valid(loc_valid),
        .loc_data(loc_data), .loc_first(loc_first), .loc_last(loc_last),
        .loc_discard(loc_discard), .flt_berr(flt_berr), .flt_sof(flt_sof)
    );

    // stim: {brk, sof, berr, fault[4:0], len[5:0], data[7:0]}
    // expected: {tx_sof, tx_berr, loc_valid, loc_first, loc_last, loc_discard, flt_berr, flt_sof}
    localparam logic [29:0] VEC [16] = '{
        {1'b0, 1'b1, 1'b0, 5'h00, 6'd2, 8'h11, 8'b10110000}, // R6 open 3-byte frame
        {1'b0, 1'b0, 1'b0, 5'h00, 6'd0, 8'h22, 8'b00100000}, // R6 middle byte
        {1'b0, 1'b0, 1'b0, 5'h04, 6'd0, 8'h33, 8'b01000000}, // R2 R5 local fault
        {1'b0, 1'b0, 1'b1, 5'h00, 6'd0, 8'h44, 8'b01000010}, // R4 tagged byte
        {1'b0, 1'b0, 1'b0, 5'h00, 6'd0, 8'h55, 8'b00101000}, // R8 last byte
        {1'b0, 1'b0, 1'b0, 5'h00, 6'd0, 8'h66, 8'b00000000}, // R7 outside frame
        {1'b0, 1'b1, 1'b0, 5'h00, 6'd0, 8'h77, 8'b10111000}, // R8 one-byte frame
        {1'b0, 1'b1, 1'b0, 5'h00, 6'd3, 8'h88, 8'b10110000}, // R6 open 4-byte frame
        {1'b0, 1'b0, 1'b0, 5'h00, 6'd0, 8'h99, 8'b00100000}, // R6
        {1'b0, 1'b1, 1'b0, 5'h00, 6'd1, 8'hAA, 8'b10110101}, // R9 clash, new 2-byte frame
        {1'b0, 1'b1, 1'b1, 5'h00, 6'd0, 8'hBB, 8'b11000010}, // R4 tagged start ignored
        {1'b0, 1'b0, 1'b0, 5'h00, 6'd0, 8'hCC, 8'b00101000}, // R8 closes
        {1'b1, 1'b0, 1'b0, 5'h00, 6'd0, 8'hDD, 8'b10000000}, // R3 break same cycle
        {1'b0, 1'b0, 1'b0, 5'h00, 6'd0, 8'hEE, 8'b00000000}, // R3 only one byte
        {1'b0, 1'b1, 1'b0, 5'h01, 6'd1, 8'hF0, 8'b11000000}, // R5 faulted start
        {1'b0, 1'b0, 1'b0, 5'h00, 6'd0, 8'h0F, 8'b00000000}  // R5 no frame opened
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic brk, input logic sof, input logic berr,
                         input logic [4:0] flt, input logic [5:0] len, input logic [7:0] d);
        rx_valid  = 1'b1;
        break_req = brk;
        rx_sof    = sof;
        rx_berr   = berr;
        rx_fault  = flt;
        frm_len   = len;
        rx_data   = d;
        @(negedge clk);
        rx_valid  = 1'b0;
        break_req = 1'b0;
    endtask

    function automatic logic [7:0] flags();
        return {tx_sof, tx_berr, loc_valid, loc_first, loc_last, loc_discard, flt_berr, flt_sof};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 in reset", {6'd0, tx_valid, loc_valid}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 after reset", flags(), 8'h00);
        chk("R12 tx_valid", {7'd0, tx_valid}, 8'h00);

        for (int i = 0; i < 16; i++) begin
            drive(VEC[i][29], VEC[i][28], VEC[i][27], VEC[i][26:22], VEC[i][21:16], VEC[i][15:8]);
            chk("R1 tx_valid", {7'd0, tx_valid}, 8'h01);
            chk("R1 tx_data", tx_data, VEC[i][15:8]);
            chk("R2 R3 R4 R6 R7 R8 R9 flags", flags(), VEC[i][7:0]);
            if (VEC[i][5]) chk("R6 loc_data", loc_data, VEC[i][15:8]);
        end

        // R1: idle cycle
        @(negedge clk);
        chk("R1 idle", {7'd0, tx_valid}, 8'h00);

        // R3: break in an idle cycle applies to the next byte
        break_req = 1'b1;
        @(negedge clk);
        break_req = 1'b0;
        chk("R3 break idle", {6'd0, tx_valid, tx_sof}, 8'h00);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 5'h00, 6'd0, 8'h5A);
        chk("R3 late break tags", {7'd0, tx_sof}, 8'h01);
        chk("R3 R7 not local", {7'd0, loc_valid}, 8'h00);

        // R11: masked byte-error fault, relay unaffected
        berr_mask = 1'b1;
        drive(1'b0, 1'b0, 1'b1, 5'h00, 6'd0, 8'hA5);
        chk("R11 berr masked", {6'd0, flt_berr, tx_berr}, 8'h01);
        berr_mask = 1'b0;

        // R11 R9 R10: masked clash still discards
        sof_mask = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 5'h00, 6'd3, 8'h3C);
        chk("R6 open", flags(), 8'b10110000);
        drive(1'b0, 1'b1, 1'b0, 5'h00, 6'd0, 8'hC3);
        chk("R11 R10 sof masked, discard kept", flags(), 8'b10111100);
        chk("R9 new first data", loc_data, 8'hC3);
        sof_mask = 1'b0;

        // R5: fault byte gives no berr pulse
        drive(1'b0, 1'b0, 1'b0, 5'h10, 6'd0, 8'h01);
        chk("R5 no berr pulse", {6'd0, flt_berr, loc_valid}, 8'h00);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule